// File: doc/BRIEF.md
# Economy Clock Divider Controller

This block turns the system clock into machine-cycle enable strobes for a small processor and its peripherals. A two-bit rate field chooses 4, 64 or 1024 system clocks per machine cycle. Software changes the rate through a register write. The block refuses orders that skip the fast rate: the two slow rates cannot be entered directly from one another. When switchback is enabled, an interrupt from an external source or an incoming serial frame pulls the rate back to divide-by-4 on its own. While a serial transfer is in flight, divide writes are locked so that the baud timing stays intact.

Two power states gate the strobes. Idle stops only the CPU strobe, and the peripheral strobe keeps running. Power-down stops both strobes and freezes the divider. A taken interrupt leaves either state. The switchback-enable bit is guarded by a timed unlock. Software writes AAh and then 55h to the unlock register, and this opens a write window that lasts a few machine cycles.

Register map (`reg_addr`): 0 = rate register (bits [1:0] rate field, bit 2 switchback enable), 1 = unlock register, 2 = power register (bit 0 idle, bit 1 power-down), 3 = unused.

Top module: `econ_clock_ctrl`

## Requirements
- R1: After reset the rate field reads 01 (01 = divide by 4, 10 = divide by 64, 11 = divide by 1024, 00 reserved) and the divider counts from zero, so the first peripheral strobe is high after the 4th rising edge following reset release.
- R2: While running, `per_stb` is a one-clock pulse whose period equals the divisor of the current rate field, and `cpu_stb` pulses in the same cycles when the block is not idle.
- R3: A rate write that asks for 10 while the field is 11, or for 11 while the field is 10, is ignored. Changes through 01 are accepted.
- R4: A rate write of the reserved code 00 is ignored and the field keeps its value.
- R5: With switchback enabled, `int_take` together with `int_ext` sets the field to 01 at the next edge, and this takes priority over a rate write in the same cycle. Without switchback, or when `int_ext` is low, the field is unchanged.
- R6: With switchback enabled, a pulse on `rx_start_fall` sets the field to 01 at the next machine-cycle boundary, which is the edge at which the next peripheral strobe rises, and not before.
- R7: While switchback is enabled and `tx_active` or `rx_active` is 1, rate-field writes are ignored. With switchback disabled the activity flags do not block writes.
- R8: In idle (power bit 0 = 1) `cpu_stb` stays low while `per_stb` keeps its period.
- R9: In power-down (power bit 1 = 1) both strobes stay low. `int_take` clears both idle and power-down at the next edge.
- R10: The switchback-enable bit (rate register bit 2) changes only on a rate write made while the unlock window is open. The window opens when a write of AAh to the unlock register is followed, with no other register write in between, by a write of 55h. It closes after 3 machine cycles or on the first rate write. Any other value in place of 55h drops the sequence.
- R11: After any change of the rate field the divider restarts, so the first strobe at the new rate is high exactly one divisor of clocks after the changing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 rate, 1 unlock, 2 power |
| reg_wdata | input | 8 | Register write data |
| int_take | input | 1 | Pulse: the CPU is vectoring to an interrupt |
| int_ext | input | 1 | The vectored interrupt comes from an external pin |
| rx_start_fall | input | 1 | Pulse: falling edge of a serial start bit detected |
| tx_active | input | 1 | A serial transmit is in progress |
| rx_active | input | 1 | A serial receive is in progress |
| cpu_stb | output | 1 | CPU machine-cycle enable strobe |
| per_stb | output | 1 | Peripheral machine-cycle enable strobe |
| div_sel | output | 2 | Current rate field |

## Verification
An interrupt switchback and a software rate write can land in the same clock. The bench provokes this by raising `int_take` with `int_ext` in the same cycle as a write of 10 at rate 01, and it expects 01 to win. A serial switchback and a strobe boundary are also tied together. The bench pulses `rx_start_fall` just after a strobe and then checks that the rate is still slow until the next strobe, at which point it must read 01 in the same sampled cycle. A seeded random run of rate requests, with the activity lock raised at random, is compared against a bench model of the legal-transition rules.

// File: rtl/econ_pkg.sv
package econ_pkg;
  // rate field codes
  localparam logic [1:0] DIV_RSVD = 2'b00;
  localparam logic [1:0] DIV_FAST = 2'b01;
  localparam logic [1:0] DIV_MID  = 2'b10;
  localparam logic [1:0] DIV_SLOW = 2'b11;

  // register addresses
  localparam logic [1:0] A_RATE   = 2'd0;
  localparam logic [1:0] A_UNLOCK = 2'd1;
  localparam logic [1:0] A_POWER  = 2'd2;

  // unlock key bytes
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } ta_state_t;

  function automatic logic rate_step_ok(input logic [1:0] cur, input logic [1:0] req);
    if (req == DIV_RSVD) return 1'b0;
    if (cur == DIV_MID  && req == DIV_SLOW) return 1'b0;
    if (cur == DIV_SLOW && req == DIV_MID)  return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/econ_strobe_gen.sv
module econ_strobe_gen
  import econ_pkg::*;
#(
  parameter int FAST_N = 4,
  parameter int MID_N  = 64,
  parameter int SLOW_N = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_q,
  input  logic       restart,
  input  logic       idle,
  input  logic       pd,
  output logic       tick,
  output logic       cpu_stb,
  output logic       per_stb
);
  localparam int CNT_W = $clog2(SLOW_N);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    case (div_q)
      DIV_MID:  last = CNT_W'(MID_N - 1);
      DIV_SLOW: last = CNT_W'(SLOW_N - 1);
      default:  last = CNT_W'(FAST_N - 1);
    endcase
  end

  assign tick = !pd && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cpu_stb <= 1'b0;
      per_stb <= 1'b0;
    end else begin
      per_stb <= tick;
      cpu_stb <= tick && !idle;
      if (restart || tick) cnt <= '0;
      else if (!pd)        cnt <= cnt + 1'b1;
    end
  end

  // R8: CPU strobe never fires without the peripheral strobe
  p_cpu_in_per_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_stb |-> per_stb);
  // R8: idle silences the CPU strobe
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    idle |=> !cpu_stb);
  // R9: power-down silences both strobes
  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    pd |=> (!per_stb && !cpu_stb));
  // R2: strobes are single-cycle pulses
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    per_stb |=> !per_stb);
endmodule

// File: rtl/econ_ta_guard.sv
module econ_ta_guard
  import econ_pkg::*;
#(
  parameter int TA_WINDOW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       tick,
  output logic       ta_open
);
  localparam int WIN_W = $clog2(TA_WINDOW + 1);

  ta_state_t        st;
  logic [WIN_W-1:0] win;

  assign ta_open = (st == TA_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= TA_IDLE;
      win <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_UNLOCK) begin
        if (st == TA_ARMED && reg_wdata == KEY_SECOND) begin
          st  <= TA_OPEN;
          win <= '0;
        end else if (reg_wdata == KEY_FIRST) begin
          st <= TA_ARMED;
        end else begin
          st <= TA_IDLE;
        end
      end else if (reg_addr == A_RATE || st == TA_ARMED) begin
        st <= TA_IDLE;
      end
    end else if (st == TA_OPEN && tick) begin
      if (win == WIN_W'(TA_WINDOW - 1)) st <= TA_IDLE;
      else                              win <= win + 1'b1;
    end
  end

  // R10: the window opens only straight after an armed state and a 55h write
  p_open_after_key_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ta_open) |-> $past(st == TA_ARMED && reg_wr && reg_addr == A_UNLOCK
                             && reg_wdata == KEY_SECOND));
  // R10: a rate write consumes the window
  p_consume_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_RATE) |=> !ta_open);
endmodule

// File: rtl/econ_rate_ctrl.sv
module econ_rate_ctrl
  import econ_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_rate,
  input  logic [2:0] wdata,
  input  logic       ta_open,
  input  logic       int_take,
  input  logic       int_ext,
  input  logic       rx_start_fall,
  input  logic       tx_active,
  input  logic       rx_active,
  input  logic       tick,
  output logic [1:0] div_q,
  output logic       restart,
  output logic       sw_en
);
  logic       pend;
  logic       sb_int;
  logic       sb_ser;
  logic       locked;
  logic       accept;
  logic [1:0] div_d;

  assign sb_int = sw_en && int_take && int_ext;
  assign sb_ser = pend && tick;
  assign locked = sw_en && (tx_active || rx_active);
  assign accept = wr_rate && !locked && rate_step_ok(div_q, wdata[1:0]);

  always_comb begin
    if (sb_int || sb_ser) div_d = DIV_FAST;
    else if (accept)      div_d = wdata[1:0];
    else                  div_d = div_q;
  end

  assign restart = (div_d != div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_FAST;
      sw_en <= 1'b0;
      pend  <= 1'b0;
    end else begin
      div_q <= div_d;
      if (wr_rate && ta_open) sw_en <= wdata[2];
      if (sb_ser)                       pend <= 1'b0;
      else if (sw_en && rx_start_fall)  pend <= 1'b1;
    end
  end

  // R4: the reserved code never appears
  p_no_rsvd_r4: assert property (@(posedge clk) disable iff (rst)
    div_q != DIV_RSVD);
  // R3: no direct hop between the two slow rates
  p_no_hop_r3: assert property (@(posedge clk) disable iff (rst)
    !(($past(div_q) == DIV_MID && div_q == DIV_SLOW) ||
      ($past(div_q) == DIV_SLOW && div_q == DIV_MID)));
  // R5: interrupt switchback lands on the fast rate
  p_int_sb_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_en && int_take && int_ext) |=> (div_q == DIV_FAST));
  // R7: activity lock holds the field
  p_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_rate && sw_en && (tx_active || rx_active) && !int_take && !pend)
      |=> $stable(div_q));
  // R10: protected bit unchanged outside the window
  p_guard_r10: assert property (@(posedge clk) disable iff (rst)
    !ta_open |=> $stable(sw_en));
endmodule

// File: rtl/econ_clock_ctrl.sv
module econ_clock_ctrl
  import econ_pkg::*;
#(
  parameter int FAST_N    = 4,
  parameter int MID_N     = 64,
  parameter int SLOW_N    = 1024,
  parameter int TA_WINDOW = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       int_take,
  input  logic       int_ext,
  input  logic       rx_start_fall,
  input  logic       tx_active,
  input  logic       rx_active,
  output logic       cpu_stb,
  output logic       per_stb,
  output logic [1:0] div_sel
);
  logic idle_q;
  logic pd_q;
  logic tick;
  logic restart;
  logic ta_open;
  logic sw_en;
  logic wr_rate;

  assign wr_rate = reg_wr && (reg_addr == A_RATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (int_take) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (reg_wr && reg_addr == A_POWER) begin
      idle_q <= reg_wdata[0];
      pd_q   <= reg_wdata[1];
    end
  end

  econ_ta_guard #(.TA_WINDOW(TA_WINDOW)) u_ta (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick(tick), .ta_open(ta_open)
  );

  econ_rate_ctrl u_rate (
    .clk(clk), .rst(rst), .wr_rate(wr_rate), .wdata(reg_wdata[2:0]),
    .ta_open(ta_open), .int_take(int_take), .int_ext(int_ext),
    .rx_start_fall(rx_start_fall), .tx_active(tx_active),
    .rx_active(rx_active), .tick(tick), .div_q(div_sel),
    .restart(restart), .sw_en(sw_en)
  );

  econ_strobe_gen #(.FAST_N(FAST_N), .MID_N(MID_N), .SLOW_N(SLOW_N)) u_stb (
    .clk(clk), .rst(rst), .div_q(div_sel), .restart(restart),
    .idle(idle_q), .pd(pd_q), .tick(tick), .cpu_stb(cpu_stb),
    .per_stb(per_stb)
  );

  // R9: a taken interrupt wakes the block
  p_wake_r9: assert property (@(posedge clk) disable iff (rst)
    int_take |=> (!idle_q && !pd_q));
endmodule

// File: tb/econ_clock_ctrl_bench.sv
module econ_clock_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       int_take = 1'b0, int_ext = 1'b0, rx_start_fall = 1'b0;
  logic       tx_active = 1'b0, rx_active = 1'b0;
  logic       cpu_stb, per_stb;
  logic [1:0] div_sel;

  int checks = 0;
  int failures = 0;
  logic [1:0] cur;

  always #2 clk = ~clk;

  econ_clock_ctrl u_econ_clock_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .int_take(int_take), .int_ext(int_ext),
    .rx_start_fall(rx_start_fall), .tx_active(tx_active),
    .rx_active(rx_active), .cpu_stb(cpu_stb), .per_stb(per_stb),
    .div_sel(div_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_int(input logic ext);
    @(negedge clk);
    int_take = 1'b1; int_ext = ext;
    @(negedge clk);
    int_take = 1'b0; int_ext = 1'b0;
  endtask

  task automatic wait_per(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!per_stb && k < 3000);
  endtask

  task automatic unlock();
    wr(2'd1, 8'hAA);
    wr(2'd1, 8'h55);
  endtask

  function automatic logic [1:0] exp_div(input logic [1:0] c, input logic [1:0] r,
                                         input logic sw, input logic busy);
    if (sw && busy) return c;
    if (r == 2'b00) return c;
    if ((c == 2'b10 && r == 2'b11) || (c == 2'b11 && r == 2'b10)) return c;
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k, ncpu, nper;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset div", div_sel, 1);
    check("R1 reset strobes", {cpu_stb, per_stb}, 0);
    wait_per(k);
    check("R1 first strobe edge", k, 4);
    // R2 period at /4 and coincident CPU strobe
    wait_per(k);
    check("R2 period /4", k, 4);
    check("R2 cpu with per", cpu_stb, 1);
    // R11 restart, R2 /64
    wr(2'd0, 8'h02);
    check("R3 01->10 accepted", div_sel, 2);
    wait_per(k);
    check("R11 first strobe after change", k, 64);
    wait_per(k);
    check("R2 period /64", k, 64);
    // R3 direct hop and R4 reserved
    wr(2'd0, 8'h03);
    check("R3 10->11 ignored", div_sel, 2);
    wr(2'd0, 8'h00);
    check("R4 reserved ignored", div_sel, 2);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h03);
    check("R3 via 01 to 11", div_sel, 3);
    wait_per(k);
    wait_per(k);
    check("R2 period /1024", k, 1024);
    wr(2'd0, 8'h02);
    check("R3 11->10 ignored", div_sel, 3);
    wr(2'd0, 8'h01);
    // R10 protected bit without unlock: switchback stays off
    wr(2'd0, 8'h06);
    check("R10 no-unlock div still written", div_sel, 2);
    pulse_int(1'b1);
    check("R10 switchback still disabled", div_sel, 2);
    // R10 proper unlock enables switchback
    unlock();
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h02);
    pulse_int(1'b0);
    check("R5 non-external interrupt no switch", div_sel, 2);
    pulse_int(1'b1);
    check("R5 interrupt switchback", div_sel, 1);
    // R10 wrong second key
    wr(2'd1, 8'hAA);
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h02);
    pulse_int(1'b1);
    check("R10 bad key keeps bit", div_sel, 1);
    // R10 late write after window
    unlock();
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h02);
    pulse_int(1'b1);
    check("R10 late write keeps bit", div_sel, 1);
    // R7 lock while active
    @(negedge clk); tx_active = 1'b1;
    wr(2'd0, 8'h06);
    check("R7 tx lock", div_sel, 1);
    @(negedge clk); tx_active = 1'b0; rx_active = 1'b1;
    wr(2'd0, 8'h06);
    check("R7 rx lock", div_sel, 1);
    @(negedge clk); rx_active = 1'b0;
    wr(2'd0, 8'h06);
    check("R7 unlocked write", div_sel, 2);
    // R6 serial switchback at machine-cycle boundary
    wait_per(k);
    rx_start_fall = 1'b1;
    @(negedge clk); rx_start_fall = 1'b0;
    check("R6 no early switch", div_sel, 2);
    wait_per(k);
    check("R6 switch at boundary", div_sel, 1);
    check("R6 boundary spacing", k, 63);
    // R5 priority over same-cycle write
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h06;
    int_take = 1'b1; int_ext = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; int_take = 1'b0; int_ext = 1'b0;
    check("R5 switchback beats write", div_sel, 1);
    // R3 R4 R7 random ordering with lock
    cur = div_sel;
    for (int i = 0; i < 60; i++) begin
      logic [1:0] r;
      logic b;
      r = 2'($urandom % 4);
      b = 1'($urandom % 2);
      @(negedge clk); tx_active = b;
      wr(2'd0, {5'b0, 1'b1, r});
      cur = exp_div(cur, r, 1'b1, b);
      check("R3 R4 R7 random rate", div_sel, cur);
      tx_active = 1'b0;
    end
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h05);
    // R8 idle
    wr(2'd2, 8'h01);
    @(negedge clk);
    ncpu = 0; nper = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ncpu += cpu_stb; nper += per_stb;
    end
    check("R8 idle cpu silent", ncpu, 0);
    check("R8 idle per runs", nper, 10);
    pulse_int(1'b0);
    wait_per(k);
    wait_per(k);
    check("R9 wake from idle", cpu_stb, 1);
    // R9 power-down
    wr(2'd2, 8'h02);
    @(negedge clk);
    ncpu = 0; nper = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      ncpu += cpu_stb; nper += per_stb;
    end
    check("R9 pd silent", ncpu + nper, 0);
    pulse_int(1'b0);
    wait_per(k);
    wait_per(k);
    check("R9 wake period", k, 4);
    check("R9 wake cpu", cpu_stb, 1);
    // R7 no lock once switchback disabled
    unlock();
    wr(2'd0, 8'h01);
    @(negedge clk); tx_active = 1'b1;
    wr(2'd0, 8'h02);
    check("R7 lock needs switchback", div_sel, 2);
    tx_active = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule